// File: doc/BRIEF.md
# Rotating Register Renamer with Loop Stage Predicates

This block supports modulo-scheduled loops. It holds a rotating base for the upper window of the general register space. On every rotating loop branch the base steps down by one, so a logical register name refers to a new physical register on each iteration. Logical registers 0 to 31 always keep their own index. Logical registers 32 to 127 are moved around the 96-entry window by the current base. Translation requests come in on a valid/ready stream. Several logical register numbers travel in one beat, and the physical indices leave on a registered valid/ready stream.

The block also runs the loop control. Software loads a loop count and an epilogue count. Each branch strobe then advances the loop by one step. While the loop count is nonzero, a 1 is shifted into the lowest stage predicate, which is the prologue and kernel fill. Once the loop count is used up, the epilogue count is decremented and a 0 is shifted in, which drains the stages one by one. The loop is done when both counts are zero. A clear input sets the rotating base and every stage predicate back to zero.

Back-pressure rules on the lookup stream:
- `lkp_ready` is high whenever the output register is empty or `res_ready` is high.
- A beat is taken when `lkp_valid` and `lkp_ready` are both high at a clock edge.
- A held result does not change until `res_ready` accepts it.

Top module: `rot_renamer`

## Requirements
- R1: After reset the following hold: `rot_pred` is zero, the rotating base is zero, both counts are zero, `loop_done` is 1, `loop_taken` is 0 and `res_valid` is 0.
- R2: A logical register number below 32 is returned unchanged, whatever the rotating base is.
- R3: A logical register L from 32 to 127 maps to 32 + ((L - 32 + base) mod 96). The base starts at 0 and steps from b to b-1 on each rotating branch, wrapping from 0 to 95.
- R4: If a branch is strobed while the loop count is nonzero:
  - the loop count decrements;
  - the predicates shift up, so bit k+1 takes bit k;
  - a 1 enters bit 0;
  - the base rotates;
  - `loop_taken` pulses high in the next cycle.
- R5: If a branch is strobed with loop count zero and epilogue count nonzero:
  - the epilogue count decrements;
  - the predicates shift with a 0 entering bit 0;
  - the base rotates;
  - `loop_taken` pulses only if the epilogue count was greater than 1.
- R6: A branch with both counts zero has no effect. Predicates, base and counts are unchanged, and `loop_taken` stays 0.
- R7: `loop_done` is high exactly when both the loop count and the epilogue count are zero.
- R8: `clr` sets the base to 0 and all predicates to 0 at the next edge. It leaves the counts alone, and a branch in the same cycle is ignored.
- R9: `ld_en` loads `ld_lc` and `ld_ec` into the counts. A branch in the same cycle is ignored.
- R10: Lookup stream behaviour:
  - `lkp_ready` = !`res_valid` || `res_ready`.
  - An accepted beat is translated with the base as it stood before that edge.
  - It appears on `res_regs` with `res_valid` one cycle later.
  - While `res_valid` is high and `res_ready` is low, `res_regs` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Return base and predicates to zero |
| ld_en | input | 1 | Load the loop and epilogue counts |
| ld_lc | input | 16 | Loop count value to load |
| ld_ec | input | 6 | Epilogue count value to load |
| br | input | 1 | Loop branch strobe |
| lkp_valid | input | 1 | Lookup beat valid |
| lkp_ready | output | 1 | Lookup beat can be accepted |
| lkp_regs | input | 21 | Three 7-bit logical numbers; lane i at bits [7i+6:7i] |
| res_valid | output | 1 | Translated beat valid |
| res_ready | input | 1 | Consumer accepts translated beat |
| res_regs | output | 21 | Three 7-bit physical indices, same lane packing |
| rot_pred | output | 48 | Stage predicates; bit k is logical predicate 16+k |
| loop_taken | output | 1 | One-cycle pulse after a taken branch |
| loop_done | output | 1 | Both counts exhausted |

## Verification
The hardest cases to reach from the ports are these:
- the base wrapping from 0 to 95 while lookups are in flight;
- the last epilogue branch, which rotates but is not taken.

The stimulus loads a loop count of 100 and strobes more than 96 branches back to back, with lookups on the upper window in the same cycles. Short loops with small epilogue counts are then run under random back-pressure and random clears and loads. A behavioural model checks every output on every clock.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  localparam int unsigned GR_TOTAL_DEF  = 128;
  localparam int unsigned GR_ROT_LO_DEF = 32;
  localparam int unsigned PR_TOTAL_DEF  = 64;
  localparam int unsigned PR_ROT_LO_DEF = 16;
  localparam int unsigned LC_W_DEF      = 16;
  localparam int unsigned EC_W_DEF      = 6;
  localparam int unsigned LANES_DEF     = 3;

  // what a branch strobe does this cycle
  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_FILL  = 2'd1,
    BR_DRAIN = 2'd2,
    BR_IDLE  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/rrn_base_ctr.sv
module rrn_base_ctr #(
  parameter int unsigned WIN = 96,
  parameter int unsigned BW  = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [BW-1:0] base
);
  localparam logic [BW-1:0] TOP = BW'(WIN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base <= '0;
    else if (clr)  base <= '0;
    else if (step) base <= (base == '0) ? TOP : base - 1'b1;
  end

  assert_base_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    base <= TOP);
endmodule

// File: rtl/rrn_loop_ctl.sv
module rrn_loop_ctl
  import rrn_pkg::*;
#(
  parameter int unsigned LC_W   = 16,
  parameter int unsigned EC_W   = 6,
  parameter int unsigned PR_WIN = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld_en,
  input  logic [LC_W-1:0]   ld_lc,
  input  logic [EC_W-1:0]   ld_ec,
  input  logic              br,
  output logic              rotate,
  output logic [PR_WIN-1:0] pred,
  output logic              taken,
  output logic              done
);
  logic [LC_W-1:0] lc;
  logic [EC_W-1:0] ec;
  br_kind_e        kind;

  always_comb begin
    if (clr || ld_en || !br) kind = BR_NONE;
    else if (lc != '0)       kind = BR_FILL;
    else if (ec != '0)       kind = BR_DRAIN;
    else                     kind = BR_IDLE;
  end

  assign rotate = (kind == BR_FILL) || (kind == BR_DRAIN);
  assign done   = (lc == '0) && (ec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc <= '0;
      ec <= '0;
    end else if (ld_en) begin
      lc <= ld_lc;
      ec <= ld_ec;
    end else if (kind == BR_FILL) begin
      lc <= lc - 1'b1;
    end else if (kind == BR_DRAIN) begin
      ec <= ec - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pred <= '0;
    else if (clr)    pred <= '0;
    else if (rotate) pred <= {pred[PR_WIN-2:0], kind == BR_FILL};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken <= 1'b0;
    else        taken <= (kind == BR_FILL) ||
                         ((kind == BR_DRAIN) && (ec != EC_W'(1)));
  end

  assert_fill_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_FILL) |=> pred[0] && taken && (lc == $past(lc) - 1'b1));
  assert_drain_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_DRAIN) |=> !pred[0] && (ec == $past(ec) - 1'b1));
  assert_idle_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_IDLE) |=> $stable(pred) && !taken && done);
  assert_load_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (lc == $past(ld_lc)) && (ec == $past(ld_ec)));
endmodule

// File: rtl/rrn_xlate.sv
module rrn_xlate #(
  parameter int unsigned GR_TOTAL  = 128,
  parameter int unsigned GR_ROT_LO = 32,
  parameter int unsigned GW        = $clog2(GR_TOTAL),
  parameter int unsigned BW        = $clog2(GR_TOTAL - GR_ROT_LO)
) (
  input  logic [GW-1:0] lreg,
  input  logic [BW-1:0] base,
  output logic [GW-1:0] preg
);
  localparam int unsigned WIN = GR_TOTAL - GR_ROT_LO;

  int unsigned off;

  always_comb begin
    off  = 0;
    preg = lreg;
    if (int'(lreg) >= int'(GR_ROT_LO)) begin
      off = int'(lreg) - GR_ROT_LO + int'(base);
      if (off >= WIN) off = off - WIN;
      preg = GW'(GR_ROT_LO + off);
    end
  end
endmodule

// File: rtl/rot_renamer.sv
module rot_renamer
  import rrn_pkg::*;
#(
  parameter int unsigned GR_TOTAL  = GR_TOTAL_DEF,
  parameter int unsigned GR_ROT_LO = GR_ROT_LO_DEF,
  parameter int unsigned PR_TOTAL  = PR_TOTAL_DEF,
  parameter int unsigned PR_ROT_LO = PR_ROT_LO_DEF,
  parameter int unsigned LC_W      = LC_W_DEF,
  parameter int unsigned EC_W      = EC_W_DEF,
  parameter int unsigned LANES     = LANES_DEF,
  localparam int unsigned GW       = $clog2(GR_TOTAL),
  localparam int unsigned PR_WIN   = PR_TOTAL - PR_ROT_LO
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ld_en,
  input  logic [LC_W-1:0]     ld_lc,
  input  logic [EC_W-1:0]     ld_ec,
  input  logic                br,
  input  logic                lkp_valid,
  output logic                lkp_ready,
  input  logic [LANES*GW-1:0] lkp_regs,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [LANES*GW-1:0] res_regs,
  output logic [PR_WIN-1:0]   rot_pred,
  output logic                loop_taken,
  output logic                loop_done
);
  localparam int unsigned WIN = GR_TOTAL - GR_ROT_LO;
  localparam int unsigned BW  = $clog2(WIN);
  localparam logic [BW-1:0] BASE_TOP = BW'(WIN - 1);
  localparam logic [GW-1:0] LOW_LIM  = GW'(GR_ROT_LO);

  logic          rotate;
  logic [BW-1:0] base;
  logic [LANES*GW-1:0] xl_regs;
  logic          lkp_fire;

  rrn_base_ctr #(.WIN(WIN), .BW(BW)) u_base (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(rotate), .base(base)
  );

  rrn_loop_ctl #(.LC_W(LC_W), .EC_W(EC_W), .PR_WIN(PR_WIN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld_en(ld_en), .ld_lc(ld_lc),
    .ld_ec(ld_ec), .br(br), .rotate(rotate), .pred(rot_pred),
    .taken(loop_taken), .done(loop_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rrn_xlate #(.GR_TOTAL(GR_TOTAL), .GR_ROT_LO(GR_ROT_LO), .GW(GW), .BW(BW)) u_xl (
      .lreg(lkp_regs[g*GW +: GW]), .base(base), .preg(xl_regs[g*GW +: GW])
    );
  end

  assign lkp_ready = !res_valid || res_ready;
  assign lkp_fire  = lkp_valid && lkp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          res_valid <= 1'b0;
    else if (lkp_fire)   res_valid <= 1'b1;
    else if (res_ready)  res_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_regs <= '0;
    else if (lkp_fire) res_regs <= xl_regs;
  end

  assert_base_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> base == (($past(base) == '0) ? BASE_TOP : $past(base) - 1'b1));
  assert_low_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_fire && (lkp_regs[GW-1:0] < LOW_LIM)) |=> res_regs[GW-1:0] == $past(lkp_regs[GW-1:0]));
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_regs));
  assert_clear_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rot_pred == '0) && (base == '0) && !loop_taken);
  assert_done_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_taken |-> !$past(loop_done) || $past(ld_en));
endmodule

// File: tb/test_rot_renamer.sv
module test_rot_renamer;
  localparam int LANES = 3;
  localparam int GW    = 7;
  localparam int PW    = 48;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clr, ld_en, br, lkp_valid, lkp_ready, res_valid, res_ready;
  logic loop_taken, loop_done;
  logic [15:0] ld_lc;
  logic [5:0]  ld_ec;
  logic [LANES*GW-1:0] lkp_regs, res_regs;
  logic [PW-1:0] rot_pred;

  rot_renamer i_rot_renamer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld_en(ld_en), .ld_lc(ld_lc),
    .ld_ec(ld_ec), .br(br), .lkp_valid(lkp_valid), .lkp_ready(lkp_ready),
    .lkp_regs(lkp_regs), .res_valid(res_valid), .res_ready(res_ready),
    .res_regs(res_regs), .rot_pred(rot_pred), .loop_taken(loop_taken),
    .loop_done(loop_done)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_rrb = 0, m_lc = 0, m_ec = 0;
  logic [PW-1:0] m_pred = '0;
  bit m_taken = 0, m_rv = 0;
  int m_res [LANES];

  function automatic int phys_of(int l, int rrb);
    if (l < 32) return l;
    return 32 + ((l - 32 + rrb) % 96);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 R5 R8 rot_pred", 64'(rot_pred), 64'(m_pred));
    chk("R7 loop_done", 64'(loop_done), 64'((m_lc == 0) && (m_ec == 0)));
    chk("R4 R5 R6 loop_taken", 64'(loop_taken), 64'(m_taken));
    chk("R10 res_valid", 64'(res_valid), 64'(m_rv));
    if (m_rv)
      for (int i = 0; i < LANES; i++)
        chk("R2 R3 res_regs lane", 64'(res_regs[i*GW +: GW]), 64'(m_res[i]));
  endtask

  task automatic cyc(bit c_clr, bit c_ld, int c_lc, int c_ec, bit c_br,
                     bit c_lv, int r0, int r1, int r2, bit c_rr);
    int n_res [LANES];
    int n_rrb, n_lc, n_ec, rr[LANES];
    logic [PW-1:0] n_pred;
    bit n_taken, n_rv, rdy;
    rr[0] = r0; rr[1] = r1; rr[2] = r2;
    clr = c_clr; ld_en = c_ld; ld_lc = 16'(c_lc); ld_ec = 6'(c_ec); br = c_br;
    lkp_valid = c_lv; res_ready = c_rr;
    for (int i = 0; i < LANES; i++) lkp_regs[i*GW +: GW] = 7'(rr[i]);
    #1;
    rdy = !m_rv || c_rr;
    chk("R10 lkp_ready", 64'(lkp_ready), 64'(rdy));
    n_res = m_res; n_rv = m_rv;
    if (c_lv && rdy) begin
      n_rv = 1;
      for (int i = 0; i < LANES; i++) n_res[i] = phys_of(rr[i], m_rrb);
    end else if (c_rr) n_rv = 0;
    n_rrb = m_rrb; n_lc = m_lc; n_ec = m_ec; n_pred = m_pred; n_taken = 0;
    if (c_clr) begin n_rrb = 0; n_pred = '0; end
    if (c_ld) begin n_lc = c_lc; n_ec = c_ec; end
    if (!c_clr && !c_ld && c_br) begin
      if (m_lc > 0) begin
        n_lc = m_lc - 1; n_pred = {m_pred[PW-2:0], 1'b1};
        n_rrb = (m_rrb + 95) % 96; n_taken = 1;
      end else if (m_ec > 0) begin
        n_ec = m_ec - 1; n_pred = {m_pred[PW-2:0], 1'b0};
        n_rrb = (m_rrb + 95) % 96; n_taken = (m_ec > 1);
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_res = n_res; m_rv = n_rv; m_rrb = n_rrb; m_lc = n_lc; m_ec = n_ec;
    m_pred = n_pred; m_taken = n_taken;
    compare_all();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    logic [PW-1:0] snap;
    rst_n = 0; clr = 0; ld_en = 0; ld_lc = '0; ld_ec = '0; br = 0;
    lkp_valid = 0; res_ready = 1; lkp_regs = '0;
    foreach (m_res[i]) m_res[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset rot_pred", 64'(rot_pred), 64'h0);
    chk("R1 reset loop_done", 64'(loop_done), 64'h1);
    chk("R1 reset res_valid", 64'(res_valid), 64'h0);
    chk("R1 reset loop_taken", 64'(loop_taken), 64'h0);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, 1, 0, 31, 32, 1);
    cyc(0, 0, 0, 0, 0, 1, 127, 64, 100, 1);
    // load a short loop; branch in same cycle ignored
    cyc(0, 1, 3, 3, 1, 0, 0, 0, 0, 1);
    chk("R9 load clears done", 64'(loop_done), 64'h0);
    // prologue/kernel fill then drain
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1, 1, 40 + k, 5, 127, 1);
    chk("R5 final drain not taken", 64'(loop_taken), 64'h0);
    chk("R7 done after drain", 64'(loop_done), 64'h1);
    snap = rot_pred;
    cyc(0, 0, 0, 0, 1, 1, 32, 33, 127, 1);
    chk("R6 idle branch keeps preds", 64'(rot_pred), 64'(snap));
    // back-pressure hold
    cyc(0, 0, 0, 0, 0, 1, 90, 10, 50, 0);
    cyc(0, 0, 0, 0, 0, 1, 91, 11, 51, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // clear with branch in same cycle
    cyc(0, 1, 2, 1, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 1, 1, 60, 61, 62, 1);
    chk("R8 clear zeroes preds", 64'(rot_pred), 64'h0);
    // long loop to wrap the base
    cyc(0, 1, 100, 1, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 102; k++)
      cyc(0, 0, 0, 0, 1, 1, 32 + (k % 96), 127, k % 32, (k % 5) != 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit c_clr, c_ld;
      c_clr = ($urandom % 64) == 0;
      c_ld  = ($urandom % 32) == 0;
      cyc(c_clr, c_ld, int'($urandom % 8), int'($urandom % 5), $urandom % 2 == 0,
          $urandom % 2 == 0, int'($urandom % 128), int'($urandom % 128),
          int'($urandom % 128), ($urandom % 4) != 0);
    end
    finish_run();
  end
endmodule